// File: doc/BRIEF.md
# Surround Matrix and Front Mixer

This block sits at both ends of a surround effect path. On the send side it forms the effect source. The source is either half the sum or half the difference of the left and right front inputs, or an auxiliary input passed through unchanged. On the return side it takes the processed (delayed) effect sample and scales it by one of three fixed gains, or drops it. It then adds the result to both front channels, with the right channel optionally receiving it with inverted sign.

The filters and the delay line are outside this block. A surrounding design connects `eff_src` to the delay path and feeds the delayed result back on `eff_ret`. The block also drives an auxiliary output that carries the returned effect. The front outputs and the auxiliary output have their own mutes. All sample buses are two's complement. Every output is registered once, so each result appears one clock after its inputs are presented.

Top module: `surround_mixer`

## Requirements
- R1: All outputs are registered with one clock of latency. While `rst_n` is low, every output is zero.
- R2: With `aux_sel` = 0 and `diff_sel` = 0, `eff_src` is (in_l + in_r) shifted right arithmetically by one, rounding toward minus infinity. For example, 3+0 gives 1 and −3+0 gives −2.
- R3: With `aux_sel` = 0 and `diff_sel` = 1, `eff_src` is (in_l − in_r) shifted right arithmetically by one.
- R4: With `aux_sel` = 1, `eff_src` equals `in_aux`, whatever the value of `diff_sel`.
- R5: `gain_sel` codes 0, 1 and 2 scale `eff_ret` by 23170/16384 (+3 dB), by 1 (0 dB) and by 11585/16384 (−3 dB). The scaled value is floor((eff_ret·K + 8192) / 16384), so for example 1000 becomes 1414, 1000 and 707, and −1000 at +3 dB becomes −1414.
- R6: `gain_sel` code 3 mutes the effect, so that `out_l` = `in_l` and `out_r` = `in_r`.
- R7: `out_l` is in_l plus the scaled effect. `out_r` is in_r plus the scaled effect when `right_inv` = 0, and in_r minus it when `right_inv` = 1.
- R8: Each front sum saturates to the signed W-bit range, from −2^(W−1) to 2^(W−1)−1.
- R9: `front_mute` = 1 forces `out_l` and `out_r` to zero and leaves `out_aux` unchanged.
- R10: `out_aux` equals `eff_ret`, or zero when `aux_mute` = 1. `aux_mute` has no effect on the front outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_l | input | W | Front left input sample |
| in_r | input | W | Front right input sample |
| in_aux | input | W | Auxiliary input sample |
| eff_ret | input | W | Returned (delayed) effect sample |
| diff_sel | input | 1 | 0: half sum, 1: half difference |
| aux_sel | input | 1 | 1: auxiliary input is the effect source |
| gain_sel | input | 2 | Effect gain code: 0 +3 dB, 1 0 dB, 2 −3 dB, 3 mute |
| right_inv | input | 1 | 1: subtract the effect on the right channel |
| front_mute | input | 1 | Zero the front outputs |
| aux_mute | input | 1 | Zero the auxiliary output |
| eff_src | output | W | Effect source sample |
| out_l | output | W | Front left output |
| out_r | output | W | Front right output |
| out_aux | output | W | Auxiliary output |

## Verification
The vectors use left and right inputs that differ, so that sum and difference give distinct sources. Odd and negative pairs show that the halving rounds toward minus infinity. Each gain code is applied to a return of 1000, where +3 dB, 0 dB and −3 dB give 1414, 1000 and 707. A negative return checks the sign of the rounding. Near-full-scale inputs, combined with in-phase and inverted right channels, drive both saturation limits. Each mute is applied on its own, to show that it silences only its own outputs.

// File: rtl/surround_mixer.sv
module surround_mixer #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] in_l,
  input  logic signed [W-1:0] in_r,
  input  logic signed [W-1:0] in_aux,
  input  logic signed [W-1:0] eff_ret,
  input  logic                diff_sel,
  input  logic                aux_sel,
  input  logic [1:0]          gain_sel,
  input  logic                right_inv,
  input  logic                front_mute,
  input  logic                aux_mute,
  output logic signed [W-1:0] eff_src,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r,
  output logic signed [W-1:0] out_aux
);
  localparam int FRAC = 14;
  localparam int PW   = W + 17;
  localparam int SW   = W + 3;
  localparam logic signed [16:0] K_UP   = 17'sd23170;
  localparam logic signed [16:0] K_UNIT = 17'sd16384;
  localparam logic signed [16:0] K_DN   = 17'sd11585;
  localparam logic signed [SW-1:0] MAXV = {4'b0000, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {4'b1111, {(W-1){1'b0}}};

  logic signed [W:0]    mix;
  logic signed [W-1:0]  src_n;
  logic signed [16:0]   k;
  logic signed [PW-1:0] prod, rnd;
  logic signed [SW-1:0] scaled, eff_g, sum_l, sum_r;

  assign mix   = diff_sel ? ({in_l[W-1], in_l} - {in_r[W-1], in_r})
                          : ({in_l[W-1], in_l} + {in_r[W-1], in_r});
  assign src_n = aux_sel ? in_aux : mix[W:1];

  always_comb begin
    case (gain_sel)
      2'd0:    k = K_UP;
      2'd1:    k = K_UNIT;
      default: k = K_DN;
    endcase
  end

  assign prod   = $signed({{17{eff_ret[W-1]}}, eff_ret}) * $signed({{W{k[16]}}, k});
  assign rnd    = prod + $signed({{(W+3){1'b0}}, 14'd8192});
  assign scaled = rnd[PW-1:FRAC];
  assign eff_g  = (gain_sel == 2'd3) ? '0 : scaled;

  assign sum_l = $signed({{3{in_l[W-1]}}, in_l}) + eff_g;
  assign sum_r = right_inv ? ($signed({{3{in_r[W-1]}}, in_r}) - eff_g)
                           : ($signed({{3{in_r[W-1]}}, in_r}) + eff_g);

  function automatic logic signed [W-1:0] clip(input logic signed [SW-1:0] x);
    if (x > MAXV)      clip = MAXV[W-1:0];
    else if (x < MINV) clip = MINV[W-1:0];
    else               clip = x[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_src <= '0;
      out_l   <= '0;
      out_r   <= '0;
      out_aux <= '0;
    end else begin
      eff_src <= src_n;
      out_l   <= front_mute ? '0 : clip(sum_l);
      out_r   <= front_mute ? '0 : clip(sum_r);
      out_aux <= aux_mute ? '0 : eff_ret;
    end
  end

  assert_aux_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aux_sel |=> eff_src == $past(in_aux));

  assert_gain_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd3 && !front_mute) |=> (out_l == $past(in_l) && out_r == $past(in_r)));

  assert_front_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    front_mute |=> (out_l == '0 && out_r == '0));

  assert_aux_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
    aux_mute |=> out_aux == '0);

  assert_aux_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_mute |=> out_aux == $past(eff_ret));

  assert_inphase_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd1 && !right_inv && !front_mute && eff_ret == '0)
      |=> (out_l == $past(in_l) && out_r == $past(in_r)));
endmodule

// File: tb/surround_mixer_test.sv
module surround_mixer_test;
  localparam int W  = 16;
  localparam int NV = 12;
  // columns: l r aux ret diff asel gain inv fmute amute | src ol or oa
  localparam int V [NV][14] = '{
    '{1000, 200, 0, 1000, 0, 0, 1, 0, 0, 0,  600, 2000, 1200, 1000},        // R2 R7 in phase
    '{1000, 200, 0, 1000, 1, 0, 0, 1, 0, 0,  400, 2414, -1214, 1000},       // R3 R5 +3dB R7 inverted
    '{0, 0, -300, 1000, 0, 1, 2, 0, 0, 0,   -300, 707, 707, 1000},          // R4 R5 -3dB
    '{5, -7, 0, 20000, 0, 0, 3, 0, 0, 0,    -1, 5, -7, 20000},              // R6
    '{30000, -30000, 0, 10000, 1, 0, 1, 1, 0, 0, 30000, 32767, -32768, 10000}, // R8 both limits
    '{30000, -30000, 0, 10000, 0, 0, 1, 0, 0, 0, 0, 32767, -20000, 10000},  // R8
    '{100, 100, 0, 50, 0, 0, 1, 0, 1, 0,    100, 0, 0, 50},                 // R9
    '{100, 100, 0, 50, 0, 0, 1, 0, 0, 1,    100, 150, 150, 0},              // R10
    '{3, 0, 0, 0, 0, 0, 1, 0, 0, 0,         1, 3, 0, 0},                    // R2 floor
    '{-3, 0, 0, -1000, 0, 0, 0, 0, 0, 0,    -2, -1417, -1414, -1000},       // R2 floor, R5 negative
    '{32767, 32767, 0, 0, 0, 0, 1, 0, 0, 0, 32767, 32767, 32767, 0},        // R2 extreme
    '{-32768, 32767, 0, 0, 1, 0, 1, 0, 0, 0, -32768, -32768, 32767, 0}      // R3 extreme
  };

  logic clk = 0, rst_n = 0;
  logic signed [W-1:0] in_l = 0, in_r = 0, in_aux = 0, eff_ret = 0;
  logic diff_sel = 0, aux_sel = 0, right_inv = 0, front_mute = 0, aux_mute = 0;
  logic [1:0] gain_sel = 0;
  logic signed [W-1:0] eff_src, out_l, out_r, out_aux;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  surround_mixer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_l(in_l), .in_r(in_r), .in_aux(in_aux),
    .eff_ret(eff_ret), .diff_sel(diff_sel), .aux_sel(aux_sel), .gain_sel(gain_sel),
    .right_inv(right_inv), .front_mute(front_mute), .aux_mute(aux_mute),
    .eff_src(eff_src), .out_l(out_l), .out_r(out_r), .out_aux(out_aux));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int r[14]);
    in_l = W'(r[0]); in_r = W'(r[1]); in_aux = W'(r[2]); eff_ret = W'(r[3]);
    diff_sel = r[4][0]; aux_sel = r[5][0]; gain_sel = r[6][1:0];
    right_inv = r[7][0]; front_mute = r[8][0]; aux_mute = r[9][0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset eff_src", int'(eff_src), 0);
    chk("R1", "reset out_l", int'(out_l), 0);
    chk("R1", "reset out_r", int'(out_r), 0);
    chk("R1", "reset out_aux", int'(out_aux), 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(V[i]);
      @(posedge clk); @(negedge clk);
      chk($sformatf("row%0d R2/R3/R4", i), "eff_src", int'(eff_src), V[i][10]);
      chk($sformatf("row%0d R5-R9", i), "out_l", int'(out_l), V[i][11]);
      chk($sformatf("row%0d R5-R9", i), "out_r", int'(out_r), V[i][12]);
      chk($sformatf("row%0d R10", i), "out_aux", int'(out_aux), V[i][13]);
    end
    // R1: one clock of latency, old value held until the edge
    drive(V[0]);
    @(posedge clk); @(negedge clk);
    drive(V[1]);
    #1 chk("R1", "latency out_r before edge", int'(out_r), 1200);
    @(posedge clk); @(negedge clk);
    chk("R1", "latency out_r after edge", int'(out_r), -1214);
    // R4: aux_sel overrides diff_sel
    drive(V[2]); diff_sel = 1;
    @(posedge clk); @(negedge clk);
    chk("R4", "eff_src with diff_sel", int'(eff_src), -300);
    // R1: reset mid-run clears outputs
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R1", "reset out_l", int'(out_l), 0);
    chk("R1", "reset out_aux", int'(out_aux), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule